// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block is the transmit half of an asynchronous serial port. Software places a word in a holding register with a write strobe. When the shifter is free, the control logic moves that word into a separate shift register. A frame is then sent on the serial output line. It starts with one low start bit. The data bits follow, least significant first. An optional parity bit comes next, and the frame ends with one or two high stop bits. The line idles high.

Because the holding register and the shift register are separate, software can queue the next word while the current frame is still going out. If a word is waiting when the last stop bit ends, the next start bit follows with no idle gap.

The bit period is set by a baud divider. The divider counts pulses from one of four count-enable sources, chosen by a select input. Three of these sources are prescaled internal enables and one is an external enable. A bit lasts 16·(n+1) of those pulses, where n is the reload value. Two status outputs report an empty holding register and an idle shifter. A latched interrupt request is raised either when the holding register is emptied or when transmission completes.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, the serial output is 1, both empty flags are 1 and the interrupt request is 0.
- R2: `srcSel` picks the count enable `srcEn[srcSel]`. Indices 0 to 2 are the prescaled internal enables and index 3 is the external enable. Each bit lasts exactly 16·(`divReload`+1) pulses of the chosen enable.
- R3: A frame begins with a start bit at 0, and the line is 1 whenever no frame is being sent.
- R4: Data bits follow the start bit, least significant first. There are 8 bits (`wrData[7:0]`) when `nineBit`=0 and 9 bits (`wrData[8:0]`) when `nineBit`=1.
- R5: With `parityOn`=1, one parity bit follows the last data bit. It is the XOR of all sent data bits, inverted when `parityOdd`=1. With `parityOn`=0, the stop bits follow the last data bit directly.
- R6: The frame ends with one stop bit at 1 when `twoStop`=0, and with two when `twoStop`=1.
- R7: `holdEmpty` drops to 0 the cycle after a write strobe. It returns to 1 in the same cycle that the word enters the shift register and the start bit appears.
- R8: `shiftEmpty` is 0 from the start bit through the last stop bit. It returns to 1 right after the last stop bit when no word is waiting.
- R9: If a word is waiting when the last stop bit ends, its start bit begins in the next cycle. `shiftEmpty` stays 0 across the boundary.
- R10: With `irqOnComplete`=1, `irqReq` is set when `shiftEmpty` rises. With `irqOnComplete`=0, it is set when a word moves from the holding register to the shifter. It stays set until an `irqClear` pulse clears it.
- R11: While `txEnable` is 0, no new frame starts. A frame already in progress is still sent in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcEn | input | 4 | Count-enable pulses: three prescaled internal enables and one external enable |
| srcSel | input | 2 | Selects the count enable |
| divReload | input | 8 | Divider reload value n |
| txEnable | input | 1 | Allows new frames to start |
| nineBit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| parityOn | input | 1 | Inserts a parity bit |
| parityOdd | input | 1 | Selects odd parity |
| twoStop | input | 1 | Selects two stop bits |
| irqOnComplete | input | 1 | Interrupt on transmission complete (1) or on holding register empty (0) |
| wrStrobe | input | 1 | Writes `wrData` into the holding register |
| wrData | input | 9 | Word to send |
| irqClear | input | 1 | Clears the interrupt request |
| txd | output | 1 | Serial output |
| holdEmpty | output | 1 | Holding register is empty |
| shiftEmpty | output | 1 | Shifter is idle |
| irqReq | output | 1 | Latched interrupt request |

## Verification
The assertions check several rules on every cycle:
- The line is high whenever the shifter is idle.
- The cycle after a load always shows a start bit.
- `holdEmpty` rises only on a load, and `shiftEmpty` rises only on a bit boundary.
- A cleared enable keeps an idle shifter idle.
- The interrupt request holds until it is cleared.

Only the bench's scenarios can show the rest: the exact bit timing for each divider and count source, the bit order, the parity value and the frame length for each configuration, the gap-free back-to-back frames, and the choice between the two interrupt conditions.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } txStrobe_t;

  typedef struct packed {
    logic nineBit;
    logic parityOn;
    logic parityOdd;
    logic twoStop;
  } txCfg_t;
endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int OVS    = 16,
  parameter int DATA_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcPulse,
  input  logic [DIV_W-1:0] divReload,
  input  logic             txEnable,
  input  logic             wrStrobe,
  input  txCfg_t           cfg,
  input  logic             irqOnComplete,
  input  logic             irqClear,
  output txStrobe_t        strb,
  output logic             holdEmpty,
  output logic             shiftEmpty,
  output logic             irqReq
);
  localparam int SUB_W = $clog2(OVS);
  localparam int LEN_W = $clog2(DATA_W + 5);

  logic             busy, holdFull;
  logic [DIV_W-1:0] divCnt;
  logic [SUB_W-1:0] subCnt;
  logic [LEN_W-1:0] bitsLeft, frameLen;
  logic             bitTick, lastBit, canLoad, frameEnd, irqSet;

  always_comb begin
    frameLen = LEN_W'(DATA_W + 2) - LEN_W'(!cfg.nineBit)
             + LEN_W'(cfg.parityOn) + LEN_W'(cfg.twoStop);
    bitTick  = busy && srcPulse && (divCnt >= divReload)
             && (subCnt == SUB_W'(OVS - 1));
    lastBit  = bitTick && (bitsLeft == LEN_W'(1));
    canLoad  = holdFull && txEnable && (!busy || lastBit);
    frameEnd = lastBit && !canLoad;
    strb.load  = canLoad;
    strb.shift = bitTick && !lastBit;
    irqSet   = irqOnComplete ? frameEnd : canLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      holdFull <= 1'b0;
      divCnt   <= '0;
      subCnt   <= '0;
      bitsLeft <= '0;
      irqReq   <= 1'b0;
    end else begin
      if (canLoad) begin
        busy     <= 1'b1;
        divCnt   <= '0;
        subCnt   <= '0;
        bitsLeft <= frameLen;
      end else begin
        if (frameEnd) busy <= 1'b0;
        if (busy && srcPulse) begin
          if (divCnt >= divReload) begin
            divCnt <= '0;
            subCnt <= subCnt + SUB_W'(1);
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        if (strb.shift) bitsLeft <= bitsLeft - LEN_W'(1);
      end
      if (wrStrobe)     holdFull <= 1'b1;
      else if (canLoad) holdFull <= 1'b0;
      if (irqSet)        irqReq <= 1'b1;
      else if (irqClear) irqReq <= 1'b0;
    end
  end

  assign holdEmpty  = !holdFull;
  assign shiftEmpty = !busy;

  // R7
  hold_empty_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEmpty) |-> $past(strb.load));
  // R8
  shift_empty_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftEmpty) |-> $past(bitTick));
  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEmpty && !txEnable) |=> shiftEmpty);
  // R10
  irq_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqClear) |=> irqReq);
endmodule

// File: rtl/uart_tx_dpath.sv
module uart_tx_dpath
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  txCfg_t            cfg,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 4;

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg, frameNext;
  logic               par;

  always_comb begin
    frameNext    = '1;
    frameNext[0] = 1'b0;
    par          = cfg.parityOdd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < DATA_W - 1 || cfg.nineBit) begin
        frameNext[i+1] = holdReg[i];
        par            = par ^ holdReg[i];
      end
    end
    if (cfg.parityOn) begin
      if (cfg.nineBit) frameNext[DATA_W+1] = par;
      else             frameNext[DATA_W]   = par;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '1;
    end else begin
      if (wrStrobe) holdReg <= wrData;
      if (strb.load)       shiftReg <= frameNext;
      else if (strb.shift) shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end
  end

  assign txd = shiftReg[0];

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.load) |-> !txd);
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int OVS    = 16,
  parameter int DATA_W = 9,
  parameter int NSRC   = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NSRC-1:0]         srcEn,
  input  logic [$clog2(NSRC)-1:0] srcSel,
  input  logic [DIV_W-1:0]        divReload,
  input  logic                    txEnable,
  input  logic                    nineBit,
  input  logic                    parityOn,
  input  logic                    parityOdd,
  input  logic                    twoStop,
  input  logic                    irqOnComplete,
  input  logic                    wrStrobe,
  input  logic [DATA_W-1:0]       wrData,
  input  logic                    irqClear,
  output logic                    txd,
  output logic                    holdEmpty,
  output logic                    shiftEmpty,
  output logic                    irqReq
);
  txStrobe_t strb;
  txCfg_t    cfg;
  logic      srcPulse;

  assign cfg      = '{nineBit: nineBit, parityOn: parityOn,
                      parityOdd: parityOdd, twoStop: twoStop};
  assign srcPulse = srcEn[srcSel];

  uart_tx_ctrl #(.DIV_W(DIV_W), .OVS(OVS), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .divReload(divReload),
    .txEnable(txEnable), .wrStrobe(wrStrobe), .cfg(cfg),
    .irqOnComplete(irqOnComplete), .irqClear(irqClear), .strb(strb),
    .holdEmpty(holdEmpty), .shiftEmpty(shiftEmpty), .irqReq(irqReq)
  );

  uart_tx_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrStrobe(wrStrobe),
    .wrData(wrData), .cfg(cfg), .txd(txd)
  );

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEmpty |-> txd);
endmodule

// File: tb/tb_uart_tx_dbuf.sv
module tb_uart_tx_dbuf;
  logic       clk = 1'b0, rstN = 1'b0;
  logic [3:0] srcEn = 4'b0001;
  logic [1:0] srcSel = 2'd0;
  logic [7:0] divReload = 8'd0;
  logic       txEnable = 1'b1, nineBit = 1'b0, parityOn = 1'b0, parityOdd = 1'b0;
  logic       twoStop = 1'b0, irqOnComplete = 1'b0, wrStrobe = 1'b0, irqClear = 1'b0;
  logic [8:0] wrData = '0;
  logic       txd, holdEmpty, shiftEmpty, irqReq;
  logic       extToggle = 1'b0;
  int         nChecks = 0, nFail = 0;
  bit         finished = 0;

  always #10 clk = ~clk;
  always @(negedge clk) if (extToggle) srcEn[3] <= ~srcEn[3];

  uart_tx_dbuf dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int frameLenOf();
    return 1 + (nineBit ? 9 : 8) + (parityOn ? 1 : 0) + (twoStop ? 2 : 1);
  endfunction

  function automatic logic [12:0] frameBits(input logic [8:0] d);
    logic [12:0] f = '1;
    int dl = nineBit ? 9 : 8;
    logic p = parityOdd;
    f[0] = 1'b0;
    for (int i = 0; i < dl; i++) begin f[1+i] = d[i]; p ^= d[i]; end
    if (parityOn) f[1+dl] = p;
    return f;
  endfunction

  function automatic string bitTag(input int b);
    int dl = nineBit ? 9 : 8;
    if (b == 0) return "R3 start";
    if (b <= dl) return "R4 data";
    if (parityOn && b == dl + 1) return "R5 parity";
    return "R6 stop";
  endfunction

  // write into an idle transmitter; returns one cycle after the load
  task automatic startWord(input logic [8:0] d);
    @(negedge clk); wrData = d; wrStrobe = 1; irqClear = 1;
    @(negedge clk); wrStrobe = 0; irqClear = 0;
    chk("R7 holdEmpty after write", holdEmpty, 0);
    chk("R8 idle before load", shiftEmpty, 1);
    @(negedge clk);
    chk("R3 start bit", txd, 0);
    chk("R7 holdEmpty after transfer", holdEmpty, 1);
    chk("R8 busy in frame", shiftEmpty, 0);
    chk("R10 irq on transfer", irqReq, irqOnComplete ? 0 : 1);
  endtask

  task automatic runFrame(input logic [12:0] bits, input int len, input int per,
                          input bit doWrite, input logic [8:0] wd, input bit dropEn);
    for (int idx = 1; idx <= len * per; idx++) begin
      @(negedge clk);
      if (doWrite && idx == per) begin
        wrData = wd; wrStrobe = 1;
        if (dropEn) txEnable = 0;
      end
      if (doWrite && idx == per + 1) begin
        wrStrobe = 0;
        chk("R7 queued word", holdEmpty, 0);
      end
      if (idx % per == per / 2) chk(bitTag(idx / per), txd, bits[idx/per]);
      if (idx == len * per - 1) chk("R8 busy to last stop", shiftEmpty, 0);
    end
  endtask

  task automatic oneFrame(input logic [8:0] d, input int n);
    int len = frameLenOf();
    int per = 16 * (n + 1);
    startWord(d);
    runFrame(frameBits(d), len, per, 0, '0, 0);
    chk("R8 idle after stop", shiftEmpty, 1);
    chk("R3 idle high", txd, 1);
    chk("R10 irq after frame", irqReq, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int unused = $urandom(32'd1234);
    int lowRun;
    repeat (3) @(negedge clk);
    chk("R1 txd", txd, 1); chk("R1 holdEmpty", holdEmpty, 1);
    chk("R1 shiftEmpty", shiftEmpty, 1); chk("R1 irq", irqReq, 0);
    rstN = 1;
    @(negedge clk);

    // directed formats
    divReload = 0; nineBit = 0; parityOn = 0; twoStop = 0; irqOnComplete = 0;
    oneFrame(9'h055, 0);
    divReload = 1; nineBit = 1; parityOn = 1; parityOdd = 0; twoStop = 1; irqOnComplete = 1;
    oneFrame(9'h1A5, 1);
    divReload = 0; nineBit = 0; parityOn = 1; parityOdd = 1; twoStop = 0; irqOnComplete = 0;
    oneFrame(9'h0F0, 0);

    // irq clear
    @(negedge clk); irqClear = 1; @(negedge clk); irqClear = 0;
    chk("R10 irq cleared", irqReq, 0);
    repeat (5) @(negedge clk);
    chk("R10 irq stays clear", irqReq, 0);

    // random frames
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      nineBit = 1'($urandom); parityOn = 1'($urandom); parityOdd = 1'($urandom);
      twoStop = 1'($urandom); irqOnComplete = 1'($urandom);
      divReload = 8'($urandom_range(0, 2));
      oneFrame(9'($urandom), int'(divReload));
    end

    // back-to-back
    @(negedge clk);
    divReload = 0; nineBit = 0; parityOn = 1; parityOdd = 0; twoStop = 1; irqOnComplete = 0;
    startWord(9'h0C3);
    runFrame(frameBits(9'h0C3), frameLenOf(), 16, 1, 9'h03C, 0);
    chk("R9 next start no gap", txd, 0);
    chk("R9 shiftEmpty stays low", shiftEmpty, 0);
    chk("R9 holdEmpty after reload", holdEmpty, 1);
    runFrame(frameBits(9'h03C), frameLenOf(), 16, 0, '0, 0);
    chk("R8 idle after pair", shiftEmpty, 1);

    // enable cleared mid-frame
    @(negedge clk);
    nineBit = 1; parityOn = 0; twoStop = 0;
    startWord(9'h133);
    runFrame(frameBits(9'h133), frameLenOf(), 16, 1, 9'h0AA, 1);
    chk("R11 frame finished", shiftEmpty, 1);
    chk("R11 word still held", holdEmpty, 0);
    chk("R11 line idle", txd, 1);
    repeat (40) @(negedge clk);
    chk("R11 no start while disabled", txd, 1);
    chk("R11 shifter idle while disabled", shiftEmpty, 1);
    txEnable = 1;
    @(negedge clk);
    chk("R11 start after enable", txd, 0);
    chk("R11 transfer after enable", holdEmpty, 1);
    runFrame(frameBits(9'h0AA), frameLenOf(), 16, 0, '0, 0);
    chk("R8 idle after resume", shiftEmpty, 1);

    // external count source at half rate
    @(negedge clk);
    nineBit = 0; parityOn = 0; twoStop = 0; divReload = 0;
    srcSel = 2'd3; extToggle = 1;
    @(negedge clk); wrData = 9'h0FF; wrStrobe = 1;
    @(negedge clk); wrStrobe = 0;
    while (txd) @(negedge clk);
    lowRun = 0;
    while (!txd) begin lowRun++; @(negedge clk); end
    chk("R2 external source bit length", int'(lowRun >= 31 && lowRun <= 33), 1);
    while (!shiftEmpty) @(negedge clk);
    srcSel = 2'd0; extToggle = 0;

    // internal source, n=3: exact timing
    @(negedge clk);
    divReload = 3;
    oneFrame(9'h0E1, 3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule